// File: doc/BRIEF.md
# Error-Rate-Ranked Shared Pipeline Allocator

This block hands out shared floating-point pipelines to operation requests. The pipelines are split into groups, one group per operation type, and each pipeline reports a measured timing-error rate. The allocator keeps every group ordered from the lowest error rate to the highest. For each request it walks that order and grants the first pipeline that is free and eligible. Together with the grant it issues the operating mode the pipeline must be set to: exact, with every fraction bit guarded, or loose, where timing errors in a number of low fraction bits are left uncorrected.

A requester raises `req_valid` with the operation type, the loose/exact flag and the number of unguarded fraction bits. It keeps the request steady until `req_ready` is seen high at a clock edge. The grant appears on the `grant_*` outputs for one cycle after that edge. A loose request may only go to a pipeline whose error rate is strictly below `approx_limit`. A granted pipeline counts as occupied until its `done_i` bit pulses. An external `busy_i` bit also removes a pipeline from selection.

Top module: `pipe_alloc`

## Requirements
- R1: While `rst` is high, `req_ready` is 0. In the cycle after reset, `grant_valid` is 0 and no pipeline is counted as occupied.
- R2: Pipeline index p belongs to type p / PER_TYPE. A grant always names a pipeline of the type that was requested.
- R3: Among the eligible free pipelines of the requested type, the one with the lowest registered error rate is chosen. When rates are equal, the lower index wins.
- R4: A pipeline whose `busy_i` bit is high in the request cycle is skipped.
- R5: A loose request (`req_approx`=1) is only granted to a pipeline whose registered rate is strictly below `approx_limit`. Exact requests ignore the limit.
- R6: `req_ready` is high exactly when `req_valid` is high and an eligible pipeline exists. If none exists, `req_ready` stays low and nothing is granted. Each accepted request produces `grant_valid` in the next cycle.
- R7: A granted pipeline is occupied from the grant edge until an edge where its `done_i` bit is high. A `done_i` pulse for a pipeline that is not occupied has no effect.
- R8: The mode output is 0 for exact and 1 for loose. For an exact grant, `grant_n` is 0. For a loose grant, `grant_n` is `req_n` limited to FRAC_W (23).
- R9: The ranking and the limit comparison use rates captured at the previous clock edge. A rate change therefore affects selection one cycle later.
- R10: At most one grant is issued per cycle. `grant_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_type | input | TYPE_W | Requested operation type |
| req_approx | input | 1 | 1 = loose mode request |
| req_n | input | N_W | Unguarded fraction bits requested |
| req_ready | output | 1 | Request accepted at this edge |
| busy_i | input | NP | External occupied flags, one per pipeline |
| done_i | input | NP | Completion pulses, one per pipeline |
| rate_i | input | NP*RATE_W | Measured error rates, pipeline p at bits p*RATE_W |
| approx_limit | input | RATE_W | Rate bound for loose requests |
| grant_valid | output | 1 | Grant pulse |
| grant_idx | output | IDX_W | Granted pipeline |
| grant_mode | output | 1 | Mode to program: 0 exact, 1 loose |
| grant_n | output | N_W | Unguarded bit count to program |

## Verification
A completion and a new request can land in the same cycle. If the completing pipeline is also the best-ranked one, the request must still go to the next candidate, and the freed pipeline only becomes available one edge later. The bench provokes this by pulsing `done_i` on an occupied low-rate pipeline while a request for its type is pending. It also changes rates and requests in the same cycle. The bench's own model applies the completion and the previous-edge rates, and the grant index is compared against that model on every cycle.

// File: rtl/pipe_alloc_pkg.sv
package pipe_alloc_pkg;
    localparam int DEF_TYPES    = 2;
    localparam int DEF_PER_TYPE = 4;
    localparam int DEF_RATE_W   = 8;
    localparam int DEF_FRAC_W   = 23;
    localparam int DEF_N_W      = 5;

    typedef enum logic {
        MODE_EXACT = 1'b0,
        MODE_LOOSE = 1'b1
    } opmode_e;

    typedef struct packed {
        logic    valid;
        opmode_e mode;
    } grant_hdr_t;

    function automatic int clamp_bits(input int n, input int lim);
        return (n > lim) ? lim : n;
    endfunction
endpackage

// File: rtl/rank_order.sv
module rank_order #(
    parameter int PER = 4,
    parameter int RW  = 8
) (
    input  logic [PER*RW-1:0]  rates,
    output logic [PER*PER-1:0] order_oh
);
    always_comb begin
        order_oh = '0;
        for (int i = 0; i < PER; i++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < PER; j++) begin
                if (j != i) begin
                    if ((rates[j*RW +: RW] < rates[i*RW +: RW]) ||
                        ((rates[j*RW +: RW] == rates[i*RW +: RW]) && (j < i)))
                        cnt++;
                end
            end
            order_oh[cnt*PER + i] = 1'b1;
        end
    end
endmodule

// File: rtl/first_pick.sv
module first_pick #(
    parameter int PER = 4,
    localparam int LW = (PER > 1) ? $clog2(PER) : 1
) (
    input  logic [PER*PER-1:0] order_oh,
    input  logic [PER-1:0]     elig,
    output logic               found,
    output logic [LW-1:0]      pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int r = 0; r < PER; r++) begin
            if (!found) begin
                for (int k = 0; k < PER; k++) begin
                    if (order_oh[r*PER + k] && elig[k]) begin
                        found = 1'b1;
                        pick  = LW'(k);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/busy_track.sv
module busy_track #(
    parameter int NP = 8,
    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [NP-1:0]    done_i,
    output logic [NP-1:0]    held
);
    logic [NP-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= (held & ~done_i) | set_vec;
    end
endmodule

// File: rtl/pipe_alloc.sv
module pipe_alloc
    import pipe_alloc_pkg::*;
#(
    parameter int N_TYPES  = DEF_TYPES,
    parameter int PER_TYPE = DEF_PER_TYPE,
    parameter int RATE_W   = DEF_RATE_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter int N_W      = DEF_N_W,
    localparam int NP      = N_TYPES * PER_TYPE,
    localparam int TYPE_W  = (N_TYPES > 1) ? $clog2(N_TYPES) : 1,
    localparam int LOC_W   = (PER_TYPE > 1) ? $clog2(PER_TYPE) : 1,
    localparam int IDX_W   = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [TYPE_W-1:0]    req_type,
    input  logic                 req_approx,
    input  logic [N_W-1:0]       req_n,
    output logic                 req_ready,
    input  logic [NP-1:0]        busy_i,
    input  logic [NP-1:0]        done_i,
    input  logic [NP*RATE_W-1:0] rate_i,
    input  logic [RATE_W-1:0]    approx_limit,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_idx,
    output logic                 grant_mode,
    output logic [N_W-1:0]       grant_n
);
    logic [NP*RATE_W-1:0]      rate_q;
    logic [NP-1:0]             held;
    logic [N_TYPES-1:0]        found_v;
    logic [N_TYPES*LOC_W-1:0]  pick_v;
    logic                      sel_found;
    logic [LOC_W-1:0]          sel_loc;
    logic [IDX_W-1:0]          sel_idx;
    grant_hdr_t                hdr_q;

    // captured rates: ranking follows measurements with one edge of lag
    always_ff @(posedge clk) begin
        if (rst) rate_q <= '0;
        else     rate_q <= rate_i;
    end

    for (genvar g = 0; g < N_TYPES; g++) begin : g_type
        logic [PER_TYPE*PER_TYPE-1:0] order_oh;
        logic [PER_TYPE-1:0]          elig;

        rank_order #(.PER(PER_TYPE), .RW(RATE_W)) u_rank (
            .rates    (rate_q[g*PER_TYPE*RATE_W +: PER_TYPE*RATE_W]),
            .order_oh (order_oh)
        );

        for (genvar k = 0; k < PER_TYPE; k++) begin : g_pipe
            localparam int P = g*PER_TYPE + k;
            assign elig[k] = !busy_i[P] && !held[P] &&
                             (!req_approx || (rate_q[P*RATE_W +: RATE_W] < approx_limit));
        end

        first_pick #(.PER(PER_TYPE)) u_pick (
            .order_oh (order_oh),
            .elig     (elig),
            .found    (found_v[g]),
            .pick     (pick_v[g*LOC_W +: LOC_W])
        );
    end

    always_comb begin
        sel_found = 1'b0;
        sel_loc   = '0;
        for (int g = 0; g < N_TYPES; g++) begin
            if (int'(req_type) == g) begin
                sel_found = found_v[g];
                sel_loc   = pick_v[g*LOC_W +: LOC_W];
            end
        end
    end

    assign sel_idx   = IDX_W'(int'(req_type) * PER_TYPE + int'(sel_loc));
    assign req_ready = !rst && req_valid && sel_found;

    busy_track #(.NP(NP)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .set_en  (req_ready),
        .set_idx (sel_idx),
        .done_i  (done_i),
        .held    (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q     <= '{valid: 1'b0, mode: MODE_EXACT};
            grant_idx <= '0;
            grant_n   <= '0;
        end else begin
            hdr_q.valid <= req_ready;
            if (req_ready) begin
                grant_idx  <= sel_idx;
                hdr_q.mode <= req_approx ? MODE_LOOSE : MODE_EXACT;
                grant_n    <= req_approx ? N_W'(clamp_bits(int'(req_n), FRAC_W)) : '0;
            end
        end
    end

    assign grant_valid = hdr_q.valid;
    assign grant_mode  = hdr_q.mode;
endmodule

// File: rtl/pipe_alloc_chk.sv
module pipe_alloc_chk #(
    parameter int NP       = 8,
    parameter int PER_TYPE = 4,
    parameter int RATE_W   = 8,
    parameter int TYPE_W   = 1,
    parameter int IDX_W    = 3,
    parameter int N_W      = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic [TYPE_W-1:0]    req_type,
    input logic [NP-1:0]        busy_i,
    input logic [NP-1:0]        held,
    input logic [NP*RATE_W-1:0] rate_q,
    input logic [RATE_W-1:0]    approx_limit,
    input logic                 grant_valid,
    input logic [IDX_W-1:0]     grant_idx,
    input logic                 grant_mode,
    input logic [N_W-1:0]       grant_n
);
    AST_NO_READY_IN_RESET: assert property (@(posedge clk) rst |-> !req_ready); // R1
    AST_TYPE_MATCH: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (int'(grant_idx) / PER_TYPE) == int'($past(req_type))); // R2
    AST_FREE_PIPE: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((($past(busy_i) | $past(held)) >> grant_idx) & NP'(1)) == '0); // R4
    AST_LOOSE_RATE: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_mode) |->
            RATE_W'($past(rate_q) >> (int'(grant_idx) * RATE_W)) < $past(approx_limit)); // R5
    AST_READY_GRANTS: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> grant_valid); // R6
    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> $past(req_ready)); // R10
    AST_HELD_SET: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> held[grant_idx]); // R7
    AST_EXACT_NZERO: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_mode) |-> grant_n == '0); // R8
endmodule

bind pipe_alloc pipe_alloc_chk #(
    .NP(NP), .PER_TYPE(PER_TYPE), .RATE_W(RATE_W),
    .TYPE_W(TYPE_W), .IDX_W(IDX_W), .N_W(N_W)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .req_type(req_type),
    .busy_i(busy_i), .held(held), .rate_q(rate_q), .approx_limit(approx_limit),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_mode(grant_mode),
    .grant_n(grant_n)
);

// File: tb/pipe_alloc_test.sv
module pipe_alloc_test;
    localparam int NT = 2, PT = 4, NP = 8, RW = 8, FW = 23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [0:0]  req_type = '0;
    logic        req_approx = 1'b0;
    logic [4:0]  req_n = '0;
    logic        req_ready;
    logic [7:0]  busy_i = '0;
    logic [7:0]  done_i = '0;
    logic [63:0] rate_i = '0;
    logic [7:0]  approx_limit = 8'd25;
    logic        grant_valid;
    logic [2:0]  grant_idx;
    logic        grant_mode;
    logic [4:0]  grant_n;

    int checks = 0, fails = 0;
    bit done_flag = 0;

    int m_held[NP];
    int m_rate[NP];
    int e_gv = 0, e_idx = 0, e_mode = 0, e_n = 0;
    string prev_tag = "R1";

    always #5 clk = ~clk;

    pipe_alloc uut (.*);

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin m_held[p] = 0; m_rate[p] = 0; end
        e_gv = 0;
    endtask

    // one cycle: check registered outputs, drive, check ready, clock, update model
    task automatic step(string tag, bit v, int typ, bit ap, int n, logic [7:0] bz, logic [7:0] dn);
        int best;
        chk(prev_tag, int'(grant_valid), e_gv, "grant_valid");
        if (e_gv != 0) begin
            chk(prev_tag, int'(grant_idx), e_idx, "grant_idx");
            chk(prev_tag, int'(grant_mode), e_mode, "grant_mode");
            chk(prev_tag, int'(grant_n), e_n, "grant_n");
        end
        req_valid = v; req_type = 1'(typ); req_approx = ap; req_n = 5'(n);
        busy_i = bz; done_i = dn;
        #1;
        best = -1;
        if (v) begin
            for (int k = 0; k < PT; k++) begin
                int p;
                p = typ*PT + k;
                if (!bz[p] && m_held[p] == 0 && (!ap || m_rate[p] < int'(approx_limit))) begin
                    if (best < 0 || m_rate[p] < m_rate[best]) best = p;
                end
            end
        end
        chk(tag, int'(req_ready), (best >= 0) ? 1 : 0, "req_ready");
        @(posedge clk);
        for (int p = 0; p < NP; p++) if (dn[p]) m_held[p] = 0;
        e_gv = (best >= 0) ? 1 : 0;
        if (best >= 0) begin
            m_held[best] = 1;
            e_idx = best;
            e_mode = ap ? 1 : 0;
            e_n = ap ? ((n > FW) ? FW : n) : 0;
        end
        for (int p = 0; p < NP; p++) m_rate[p] = int'(rate_i[p*RW +: RW]);
        prev_tag = tag;
        @(negedge clk);
    endtask

    function automatic logic [63:0] pack(int r0, int r1, int r2, int r3,
                                         int r4, int r5, int r6, int r7);
        return {8'(r7), 8'(r6), 8'(r5), 8'(r4), 8'(r3), 8'(r2), 8'(r1), 8'(r0)};
    endfunction

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1", int'(req_ready), 0, "ready in reset");
        req_valid = 1'b1;
        #1 chk("R1", int'(req_ready), 0, "ready in reset with request");
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", int'(grant_valid), 0, "grant after reset");

        // R9: rates change in the request cycle; old (all zero) ranking applies
        rate_i = pack(40, 10, 30, 20, 50, 50, 50, 50);
        step("R9", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R7", 0, 0, 0, 0, 8'h00, 8'h01);
        // R3: ascending rate order within type 0; R2 group check
        step("R3", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R3", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R2", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R3", 1, 0, 0, 0, 8'h00, 8'h00);
        // R6: all of type 0 occupied -> stall
        step("R6", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R6", 1, 0, 0, 0, 8'h00, 8'h00);
        // completion and request in one cycle: freed pipe only usable next edge (R7)
        step("R7", 1, 0, 0, 0, 8'h00, 8'h02);
        step("R7", 1, 0, 0, 0, 8'h00, 8'h00);
        // R7: done for a pipeline that is not occupied is ignored
        step("R7", 0, 0, 0, 0, 8'h00, 8'h10);
        step("R7", 0, 0, 0, 0, 8'h00, 8'h0F);
        // R4: busy inputs skip the best candidates
        step("R4", 1, 0, 0, 0, 8'h0A, 8'h00);
        step("R4", 0, 0, 0, 0, 8'h00, 8'h0F);
        // R5: loose request, limit 25 -> only rates 10 and 20 eligible
        step("R5", 1, 0, 1, 20, 8'h02, 8'h00);
        step("R5", 1, 0, 1, 20, 8'h02, 8'h00);
        step("R5", 0, 0, 0, 0, 8'h00, 8'h0F);
        // R5: exact request ignores the limit
        step("R5", 1, 1, 0, 0, 8'h00, 8'h00);
        // R3 ties: equal rates in type 1 -> lowest free index
        step("R3", 1, 1, 0, 0, 8'h00, 8'h00);
        // R8: clamp of the unguarded count, loose with limit above rates
        approx_limit = 8'd60;
        step("R8", 1, 1, 1, 30, 8'h00, 8'h00);
        step("R8", 1, 1, 1, 7, 8'h00, 8'h00);
        step("R6", 1, 1, 1, 7, 8'h00, 8'h00);
        step("R8", 0, 0, 0, 0, 8'h00, 8'hF0);
        // R10: grant pulse lasts one cycle
        step("R10", 1, 1, 0, 0, 8'h00, 8'h00);
        step("R10", 0, 1, 0, 0, 8'h00, 8'h00);
        step("R10", 0, 1, 0, 0, 8'h00, 8'hFF);
        // R9: rate update reorders type 0 after one edge
        rate_i = pack(5, 90, 90, 1, 50, 3, 50, 50);
        step("R9", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R9", 1, 0, 0, 0, 8'h00, 8'h00);
        step("R9", 1, 1, 0, 0, 8'h00, 8'hFF);
        // mixed random traffic checked against the model
        for (int c = 0; c < 400; c++) begin
            if (c % 37 == 0)
                rate_i = {$urandom, $urandom} & 64'h3F3F_3F3F_3F3F_3F3F;
            approx_limit = 8'($urandom_range(0, 63));
            step("R3", ($urandom % 4) != 0, int'($urandom % 2), 1'($urandom),
                 int'($urandom % 32), 8'($urandom) & 8'h11, 8'($urandom) & 8'h66);
        end
        step("R10", 0, 0, 0, 0, 8'h00, 8'hFF);
        step("R10", 0, 0, 0, 0, 8'h00, 8'h00);
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule